// File: doc/BRIEF.md
# Noncritical Interrupt Entry Sequencer

This block owns the processor's machine-state word and the two save registers used by noncritical, asynchronous interrupts such as the interval-timer and external interrupts. Each clock cycle it looks at the pending noncritical requests and their per-source enables. When the external-enable bit of the machine-state word is set and at least one enabled request is pending, it accepts the request with the highest priority. On one clock edge it then stores the next-sequential program counter and the pre-interrupt machine state in the save registers, clears a fixed group of machine-state bits, and issues a one-cycle fetch redirect to the vector of the accepted source.

A return command reverses the entry. It reloads the machine state from the saved copy and redirects fetch to the saved program counter. Software can also load the machine-state word directly, for example to enable interrupts again inside a handler. Critical-class save registers, syndrome registers, pipeline flushing and cache effects are handled elsewhere.

Top module: `ncint_entry_seq`

## Requirements
- R1: While reset is low at a clock edge, the machine state, both save registers, the redirect target and the acknowledge vector all become 0, and redirect_valid becomes 0.
- R2: A request is accepted at a clock edge when machine-state bit 15 (external enable) is 1, rfi_valid is 0, and some source i has both irq_req[i] and irq_en[i] set. After that edge, redirect_valid and exactly one bit of irq_ack (the accepted source) are 1 for one cycle.
- R3: On acceptance, save_pc takes the value of next_pc.
- R4: On acceptance, save_state takes the machine state from before the edge.
- R5: On acceptance, the machine state becomes its old value AND 0xFDEB12CF. Bits 25, 20, 18, 15, 14, 13, 11, 10, 8, 5 and 4 are cleared. Bits 17, 12 and 9 (critical, machine-check and debug enables) and all other bits are kept.
- R6: The redirect target on acceptance is {vec_base[31:16], offset}. The offsets are 0x0500 for source 0, 0x1000 for source 1 (timer) and 0x1010 for source 2.
- R7: When several enabled requests are pending, the source with the lowest index is accepted.
- R8: With bit 15 clear, or with no pending request whose enable is set, nothing is accepted. There is no redirect, and the machine state and save registers keep their values.
- R9: A request that stays pending is not accepted again on the edge after an acceptance, because bit 15 has been cleared.
- R10: When rfi_valid is 1 at an edge, the machine state is loaded from save_state and a one-cycle redirect to save_pc is issued. Both save registers are left unchanged.
- R11: A request pending during an rfi cycle is not accepted on that edge. If it is still pending and the restored bit 15 is 1, it is accepted on the next edge.
- R12: When state_wr_valid is 1, the machine state loads state_wr_data, unless an rfi or an acceptance happens on the same edge. In that case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 3 | Pending noncritical requests, one per source |
| irq_en | input | 3 | Per-source enables |
| next_pc | input | 32 | Address of the next sequential instruction |
| vec_base | input | 32 | Vector base; the upper 16 bits are used |
| rfi_valid | input | 1 | Return-from-interrupt command |
| state_wr_valid | input | 1 | Software load of the machine state |
| state_wr_data | input | 32 | Value for the software load |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | Redirect target |
| irq_ack | output | 3 | One-hot acknowledge of the accepted source |
| mstate | output | 32 | Current machine-state word |
| save_pc | output | 32 | Saved program counter |
| save_state | output | 32 | Saved machine-state word |

## Verification
The bench aims at the machine-state mask with all bits set and with only the kept enables set. A design that cleared the critical, machine-check or debug enables, or that kept the wait or translation bits, shows the wrong word after entry. It also drives a request that stays pending across several edges: a sequencer that failed to clear external enable would take the interrupt again at once, and one that let a pending request win over a return would corrupt the save registers. It then lines up a software state load with an entry on the same edge, checks the priority among the sources, and masks a source through its enable, where a wrong decode jumps to the wrong vector.

// File: rtl/ncint_pkg.sv
// Package: shared types, machine-state bit positions and the entry clear mask.
// Assumes a 32-bit machine-state word and 32-bit addresses.
package ncint_pkg;
    localparam int WORD_W = 32;
    localparam int OFF_W  = 16;
    typedef logic [WORD_W-1:0] word_t;

    // Machine-state bit positions used by the sequencer
    localparam int BIT_EXT_EN  = 15;
    localparam int BIT_CRIT_EN = 17;
    localparam int BIT_MCHK_EN = 12;
    localparam int BIT_DBG_EN  = 9;

    // Bits forced to zero on interrupt entry
    localparam int NUM_CLR = 11;
    localparam int CLR_POS [NUM_CLR] = '{25, 20, 18, 15, 14, 13, 11, 10, 8, 5, 4};

    // Build the entry clear mask from the position list
    function automatic word_t entry_clear_mask();
        word_t m;
        m = '0;
        for (int k = 0; k < NUM_CLR; k++) begin
            m[CLR_POS[k]] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ncint_arbiter.sv
// Module: ncint_arbiter
// Picks the enabled pending source with the lowest index and outputs its
// vector offset. Purely combinational; assumes OFFSETS packs one offset per
// source, source 0 in the low slice.
module ncint_arbiter #(
    parameter int NUM_SRC = 3,
    parameter int OFF_W   = 16,
    parameter logic [NUM_SRC*OFF_W-1:0] OFFSETS = '0
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] grant,
    output logic               any,
    output logic [OFF_W-1:0]   offset
);
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC:0]   blocked;

    assign live       = req & en;
    assign blocked[0] = 1'b0;

    // Fixed-priority chain: each source is blocked by any lower index live source
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
        assign grant[i]     = live[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | live[i];
    end

    assign any = blocked[NUM_SRC];

    // Select the offset of the granted source
    always_comb begin
        offset = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) offset = OFFSETS[i*OFF_W +: OFF_W];
        end
    end
endmodule

// File: rtl/ncint_state_mask.sv
// Module: ncint_state_mask
// Produces the machine-state value after interrupt entry: the bits in the
// package clear list become 0, every other bit passes through.
module ncint_state_mask
    import ncint_pkg::*;
(
    input  word_t cur,
    output word_t entered
);
    localparam word_t CLR_MASK = entry_clear_mask();

    // Per-bit choice between forced zero and pass-through
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (CLR_MASK[b]) begin : g_clr
            assign entered[b] = 1'b0;
        end else begin : g_keep
            assign entered[b] = cur[b];
        end
    end
endmodule

// File: rtl/ncint_regs.sv
// Module: ncint_regs
// Holds the machine state, the two save registers and the registered
// redirect/acknowledge outputs. Update priority: reset, return, entry,
// software load. Assumes take is never high together with rfi.
module ncint_regs
    import ncint_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [NUM_SRC-1:0] grant,
    input  word_t              target,
    input  word_t              entered,
    input  word_t              next_pc,
    input  logic               rfi,
    input  logic               wr_valid,
    input  word_t              wr_data,
    output word_t              mstate_q,
    output word_t              save_pc_q,
    output word_t              save_state_q,
    output logic               redir_valid_q,
    output word_t              redir_pc_q,
    output logic [NUM_SRC-1:0] ack_q
);
    // Machine-state register and save registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mstate_q     <= '0;
            save_pc_q    <= '0;
            save_state_q <= '0;
        end else if (rfi) begin
            mstate_q <= save_state_q;
        end else if (take) begin
            save_pc_q    <= next_pc;
            save_state_q <= mstate_q;
            mstate_q     <= entered;
        end else if (wr_valid) begin
            mstate_q <= wr_data;
        end
    end

    // Registered redirect and acknowledge outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid_q <= 1'b0;
            redir_pc_q    <= '0;
            ack_q         <= '0;
        end else begin
            redir_valid_q <= rfi | take;
            ack_q         <= take ? grant : '0;
            if (rfi)       redir_pc_q <= save_pc_q;
            else if (take) redir_pc_q <= target;
        end
    end

    // R10: a return leaves both save registers untouched
    a_r10_save_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rfi |=> ($stable(save_pc_q) && $stable(save_state_q)));

    // R12: a load with no competing event lands in the machine state
    a_r12_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rfi && !take) |=> (mstate_q == $past(wr_data)));
endmodule

// File: rtl/ncint_entry_seq.sv
// Module: ncint_entry_seq (top)
// Noncritical interrupt entry and return sequencer. Accepts one enabled
// request when external enable is set, saves context, masks the machine
// state and redirects to the source's vector; rfi undoes the entry.
// Assumes the redirect is consumed the cycle it is shown.
module ncint_entry_seq
    import ncint_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter logic [NUM_SRC*OFF_W-1:0] SRC_OFFSETS = {16'h1010, 16'h1000, 16'h0500}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [31:0]        next_pc,
    input  logic [31:0]        vec_base,
    input  logic               rfi_valid,
    input  logic               state_wr_valid,
    input  logic [31:0]        state_wr_data,
    output logic               redirect_valid,
    output logic [31:0]        redirect_pc,
    output logic [NUM_SRC-1:0] irq_ack,
    output logic [31:0]        mstate,
    output logic [31:0]        save_pc,
    output logic [31:0]        save_state
);
    localparam int    BASE_W   = WORD_W - OFF_W;
    localparam word_t CLR_MASK = entry_clear_mask();

    logic [NUM_SRC-1:0] grant;
    logic               any_live;
    logic [OFF_W-1:0]   offset;
    logic               take;
    word_t              target;
    word_t              entered;
    word_t              mstate_q;

    ncint_arbiter #(
        .NUM_SRC (NUM_SRC),
        .OFF_W   (OFF_W),
        .OFFSETS (SRC_OFFSETS)
    ) u_arb (
        .req    (irq_req),
        .en     (irq_en),
        .grant  (grant),
        .any    (any_live),
        .offset (offset)
    );

    ncint_state_mask u_mask (
        .cur     (mstate_q),
        .entered (entered)
    );

    // Acceptance: external enable set, a live source, and no return this cycle
    assign take   = mstate_q[BIT_EXT_EN] & any_live & ~rfi_valid;
    assign target = {vec_base[WORD_W-1 -: BASE_W], offset};

    ncint_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .grant         (grant),
        .target        (target),
        .entered       (entered),
        .next_pc       (next_pc),
        .rfi           (rfi_valid),
        .wr_valid      (state_wr_valid),
        .wr_data       (state_wr_data),
        .mstate_q      (mstate_q),
        .save_pc_q     (save_pc),
        .save_state_q  (save_state),
        .redir_valid_q (redirect_valid),
        .redir_pc_q    (redirect_pc),
        .ack_q         (irq_ack)
    );

    assign mstate = mstate_q;

    // R2: acknowledge is one-hot at most and only with a redirect
    a_r2_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack) && ((irq_ack != '0) -> redirect_valid));

    // R3/R4: save registers capture the pre-entry context
    a_r4_saved_context: assert property (@(posedge clk) disable iff (!rst_n)
        (take) |=> (save_state == $past(mstate_q) && save_pc == $past(next_pc)));

    // R5: entry clears exactly the listed bits and keeps the rest
    a_r5_entry_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (take) |=> (mstate_q == ($past(mstate_q) & ~CLR_MASK)));

    // R9: no back-to-back acceptance
    a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |=> (irq_ack == '0));

    // R10: return restores the saved state and redirects to the saved PC
    a_r10_restore: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_valid |=> (mstate_q == $past(save_state) && redirect_pc == $past(save_pc)
                       && redirect_valid));

    // R11: nothing is accepted on a return edge
    a_r11_rfi_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_valid |=> (irq_ack == '0));

    // R8: without external enable nothing is acknowledged
    a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!mstate_q[BIT_EXT_EN]) |=> (irq_ack == '0));
endmodule

// File: tb/ncint_entry_seq_test.sv
// Bench for ncint_entry_seq: a vector table walked by one loop, then directed
// tests for reset, re-entry blocking, return and load collisions.
module ncint_entry_seq_test;
    localparam logic [31:0] KEEP = 32'hFDEB12CF;
    localparam logic [31:0] BASE = 32'hABCD0000;

    typedef struct packed {
        logic [31:0] init;
        logic [2:0]  req;
        logic [2:0]  en;
        logic [31:0] pc;
        logic        taken;
        logic [2:0]  ack;
        logic [31:0] target;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'hFFFFFFFF, 3'b010, 3'b111, 32'h00000100, 1'b1, 3'b010, 32'hABCD1000},
        '{32'h00008000, 3'b001, 3'b001, 32'h00000204, 1'b1, 3'b001, 32'hABCD0500},
        '{32'h00029200, 3'b110, 3'b110, 32'h00000308, 1'b1, 3'b010, 32'hABCD1000},
        '{32'h00008000, 3'b100, 3'b100, 32'h0000040C, 1'b1, 3'b100, 32'hABCD1010},
        '{32'hFFFF7FFF, 3'b111, 3'b111, 32'h00000510, 1'b0, 3'b000, 32'h0},
        '{32'h00008000, 3'b111, 3'b000, 32'h00000614, 1'b0, 3'b000, 32'h0},
        '{32'h00008000, 3'b101, 3'b100, 32'h00000718, 1'b1, 3'b100, 32'hABCD1010}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  irq_req, irq_en, irq_ack;
    logic [31:0] next_pc, vec_base, state_wr_data;
    logic        rfi_valid, state_wr_valid, redirect_valid;
    logic [31:0] redirect_pc, mstate, save_pc, save_state;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ncint_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .next_pc(next_pc), .vec_base(vec_base), .rfi_valid(rfi_valid),
        .state_wr_valid(state_wr_valid), .state_wr_data(state_wr_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .irq_ack(irq_ack), .mstate(mstate), .save_pc(save_pc),
        .save_state(save_state)
    );

    // Compare one value and log a failure line
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; irq_en = '0; next_pc = '0; vec_base = BASE;
        rfi_valid = 1'b0; state_wr_valid = 1'b0; state_wr_data = '0;
        repeat (2) step();
        // R1: reset state
        check("R1 mstate", mstate, 0);
        check("R1 save_pc", save_pc, 0);
        check("R1 save_state", save_state, 0);
        check("R1 redirect_valid", {31'b0, redirect_valid}, 0);
        check("R1 irq_ack", {29'b0, irq_ack}, 0);
        rst_n = 1'b1;
        step();

        // Vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [31:0] sp0, ss0;
            sp0 = save_pc; ss0 = save_state;
            state_wr_valid = 1'b1; state_wr_data = VECS[i].init;
            step();
            state_wr_valid = 1'b0;
            irq_req = VECS[i].req; irq_en = VECS[i].en; next_pc = VECS[i].pc;
            step();
            irq_req = '0;
            check("R2 redirect_valid", {31'b0, redirect_valid}, {31'b0, VECS[i].taken});
            check("R7 irq_ack", {29'b0, irq_ack}, {29'b0, VECS[i].ack});
            if (VECS[i].taken) begin
                check("R6 redirect_pc", redirect_pc, VECS[i].target);
                check("R3 save_pc", save_pc, VECS[i].pc);
                check("R4 save_state", save_state, VECS[i].init);
                check("R5 mstate", mstate, VECS[i].init & KEEP);
            end else begin
                check("R8 mstate", mstate, VECS[i].init);
                check("R8 save_pc", save_pc, sp0);
                check("R8 save_state", save_state, ss0);
            end
        end

        // R9: held request is not re-accepted after entry
        state_wr_valid = 1'b1; state_wr_data = 32'h00008001;
        step();
        state_wr_valid = 1'b0; irq_req = 3'b010; irq_en = 3'b111; next_pc = 32'h2000;
        step();
        check("R2 entry redirect", redirect_pc, 32'hABCD1000);
        step();
        check("R9 no re-entry", {31'b0, redirect_valid}, 0);
        check("R9 mstate", mstate, 32'h00000001);

        // R10/R11: return wins over the pending request
        rfi_valid = 1'b1; next_pc = 32'h3000;
        step();
        rfi_valid = 1'b0;
        check("R10 redirect_valid", {31'b0, redirect_valid}, 1);
        check("R10 redirect_pc", redirect_pc, 32'h2000);
        check("R10 mstate", mstate, 32'h00008001);
        check("R10 save_pc kept", save_pc, 32'h2000);
        check("R10 save_state kept", save_state, 32'h00008001);
        check("R11 irq_ack on rfi", {29'b0, irq_ack}, 0);
        step();
        check("R11 accepted after rfi", redirect_pc, 32'hABCD1000);
        check("R11 save_pc", save_pc, 32'h3000);
        irq_req = '0;

        // R12: a load on an entry edge is dropped, a lone load lands
        state_wr_valid = 1'b1; state_wr_data = 32'h00008000;
        step();
        state_wr_data = 32'h0000FFFF; irq_req = 3'b001; irq_en = 3'b001;
        step();
        irq_req = '0;
        check("R12 dropped load", mstate, 32'h0);
        check("R12 save_state", save_state, 32'h00008000);
        step();
        state_wr_valid = 1'b0;
        check("R12 lone load", mstate, 32'h0000FFFF);

        // R1: reset in mid-operation
        rst_n = 1'b0;
        step();
        check("R1 mstate again", mstate, 0);
        check("R1 save_pc again", save_pc, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule